// File: doc/BRIEF.md
# DRAM Request Timing Sequencer

This block sits on the controller side of a banked DRAM. It turns one transaction (read or write, a bank, a row, and a run of consecutive columns) into a stream of request packets. The stream is one activate, then one column command per column, then one precharge. Each packet is issued at the earliest cycle that every minimum spacing allows. A pulse on the data side marks the exact cycle in which write data must be driven or read data captured.

Only one bank is open at a time. A transaction is taken through a ready/valid handshake, and the next one is accepted only once the precharge of the current one has gone out. All spacings and latencies are parameters. An internal down-counter holds the spacing that is still pending, and the next packet leaves when it reaches zero. Cycles without a command carry a no-operation code.

Top module: `dram_req_seq`

## Requirements
- R1: While `rst_n` is low, `rq_cmd` is NOP (code 0), `rq_bank` and `rq_addr` are zero, `wr_strobe` and `rd_capture` are low, and `txn_ready` is high.
- R2: A transaction is accepted at a rising edge where `txn_valid` and `txn_ready` are both high. In the cycle after that edge, `rq_cmd` shows ACT (code 1) with the transaction's bank on `rq_bank` and its row on `rq_addr`. `txn_ready` stays low from the ACT cycle until the cycle that shows the precharge, and is high in that cycle.
- R3: A transaction issues `txn_cols_m1`+1 column commands, WR (code 2) for writes and RD (code 3) for reads. Each carries the bank and a column on `rq_addr`. The columns run `txn_col`, `txn_col`+1, and so on, wrapping modulo 2^COL_W.
- R4: The first column command comes exactly T_ACT_WR cycles (writes) or T_ACT_RD cycles (reads) after the ACT.
- R5: Successive column commands of one transaction are exactly T_COL cycles apart.
- R6: PRE (code 4) carries the bank and a zero `rq_addr`. It comes exactly T_WR_PRE cycles after the last WR, or T_RD_PRE cycles after the last RD.
- R7: `wr_strobe` is high for exactly one cycle, T_WR_DATA cycles after each WR packet, and at no other time.
- R8: `rd_capture` is high for exactly one cycle, T_RD_DATA cycles after each RD packet, and at no other time.
- R9: At most one command is issued per cycle. Every cycle without a command shows NOP with zero bank and address.
- R10: If `txn_valid` is already high when the precharge cycle arrives, the next ACT follows that precharge on the very next cycle.
- R11: `txn_valid` and the transaction fields are ignored while `txn_ready` is low. A request that is withdrawn before ready returns produces no packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txn_valid | input | 1 | Transaction offered |
| txn_ready | output | 1 | Sequencer idle, can accept a transaction |
| txn_write | input | 1 | 1 = write transaction, 0 = read |
| txn_bank | input | BANK_W | Target bank |
| txn_row | input | ROW_W | Row to activate |
| txn_col | input | COL_W | First column of the run |
| txn_cols_m1 | input | NCOL_W | Number of column commands minus one |
| rq_cmd | output | 3 | Request command: 0 NOP, 1 ACT, 2 WR, 3 RD, 4 PRE |
| rq_bank | output | BANK_W | Bank operand of the request packet |
| rq_addr | output | max(ROW_W,COL_W) | Row (ACT) or column (WR/RD) operand, zero otherwise |
| wr_strobe | output | 1 | Drive write data on the data bus this cycle |
| rd_capture | output | 1 | Capture read data from the data bus this cycle |

## Verification
The assertions are checked on every cycle. They cover the quiet NOP encoding, the ACT that follows an accepted handshake, and `txn_ready` held low while a bank is open. They also cover each spacing being at least its minimum and every data pulse being matched by an earlier column command. Only the bench scenarios can show that each spacing is met exactly rather than merely respected, and that column addresses wrap correctly. The same holds for back-to-back transactions, for a request withdrawn while busy leaving no trace, and for a read pulse that lands after its own precharge.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_WR  = 3'd2,
    CMD_RD  = 3'd3,
    CMD_PRE = 3'd4
  } rq_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_COL,
    ST_PRE
  } seq_state_e;

endpackage

// File: rtl/seq_gap_timer.sv
// Down-counter holding the remaining spacing before the next packet may leave.
module seq_gap_timer #(
  parameter int GAP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [GAP_W-1:0] load_val,
  output logic             expired
);

  logic [GAP_W-1:0] cnt_q;
  logic [GAP_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/seq_pulse_delay.sv
// Fixed delay line for one-bit data-bus pulses.
module seq_pulse_delay #(
  parameter int DEPTH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  generate
    if (DEPTH == 1) begin : g_single
      logic stage_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q <= 1'b0;
        end else begin
          stage_q <= din;
        end
      end
      assign dout = stage_q;
    end else begin : g_chain
      logic [DEPTH-1:0] stage_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q <= '0;
        end else begin
          stage_q <= {stage_q[DEPTH-2:0], din};
        end
      end
      assign dout = stage_q[DEPTH-1];
    end
  endgenerate

endmodule

// File: rtl/dram_req_seq.sv
module dram_req_seq
  import dram_seq_pkg::*;
#(
  parameter int BANK_W    = 3,
  parameter int ROW_W     = 12,
  parameter int COL_W     = 6,
  parameter int NCOL_W    = 4,
  parameter int T_ACT_WR  = 1,
  parameter int T_ACT_RD  = 5,
  parameter int T_COL     = 2,
  parameter int T_WR_DATA = 3,
  parameter int T_RD_DATA = 6,
  parameter int T_WR_PRE  = 10,
  parameter int T_RD_PRE  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    txn_valid,
  output logic                    txn_ready,
  input  logic                    txn_write,
  input  logic [BANK_W-1:0]       txn_bank,
  input  logic [ROW_W-1:0]        txn_row,
  input  logic [COL_W-1:0]        txn_col,
  input  logic [NCOL_W-1:0]       txn_cols_m1,
  output logic [2:0]              rq_cmd,
  output logic [BANK_W-1:0]       rq_bank,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] rq_addr,
  output logic                    wr_strobe,
  output logic                    rd_capture
);

  localparam int ADDR_W   = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int MAX_AB   = (T_ACT_WR > T_ACT_RD) ? T_ACT_WR : T_ACT_RD;
  localparam int MAX_PRE  = (T_WR_PRE > T_RD_PRE) ? T_WR_PRE : T_RD_PRE;
  localparam int MAX_CP   = (T_COL > MAX_PRE) ? T_COL : MAX_PRE;
  localparam int GAP_MAX  = (MAX_AB > MAX_CP) ? MAX_AB : MAX_CP;
  localparam int GAP_W    = $clog2(GAP_MAX + 1);

  // Transaction context
  seq_state_e          state_q, state_d;
  logic                is_wr_q;
  logic [BANK_W-1:0]   bank_q;
  logic [COL_W-1:0]    col_q, col_d;
  logic [NCOL_W-1:0]   left_q, left_d;
  logic                accept;

  // Registered request packet
  rq_cmd_e             cmd_q, cmd_d;
  logic [BANK_W-1:0]   obank_q, obank_d;
  logic [ADDR_W-1:0]   oaddr_q, oaddr_d;

  // Spacing timer
  logic                gap_load;
  logic [GAP_W-1:0]    gap_val;
  logic                gap_done;

  assign txn_ready = (state_q == ST_IDLE);
  assign accept    = txn_ready && txn_valid;

  seq_gap_timer #(.GAP_W(GAP_W)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (gap_load),
    .load_val (gap_val),
    .expired  (gap_done)
  );

  // Next-state and packet selection
  always_comb begin
    state_d  = state_q;
    col_d    = col_q;
    left_d   = left_q;
    cmd_d    = CMD_NOP;
    obank_d  = '0;
    oaddr_d  = '0;
    gap_load = 1'b0;
    gap_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (txn_valid) begin
          cmd_d    = CMD_ACT;
          obank_d  = txn_bank;
          oaddr_d  = ADDR_W'(txn_row);
          col_d    = txn_col;
          left_d   = txn_cols_m1;
          gap_load = 1'b1;
          gap_val  = txn_write ? GAP_W'(T_ACT_WR - 1) : GAP_W'(T_ACT_RD - 1);
          state_d  = ST_COL;
        end
      end
      ST_COL: begin
        if (gap_done) begin
          cmd_d    = is_wr_q ? CMD_WR : CMD_RD;
          obank_d  = bank_q;
          oaddr_d  = ADDR_W'(col_q);
          gap_load = 1'b1;
          if (left_q == '0) begin
            gap_val = is_wr_q ? GAP_W'(T_WR_PRE - 1) : GAP_W'(T_RD_PRE - 1);
            state_d = ST_PRE;
          end else begin
            gap_val = GAP_W'(T_COL - 1);
            left_d  = left_q - 1'b1;
            col_d   = col_q + 1'b1;
          end
        end
      end
      ST_PRE: begin
        if (gap_done) begin
          cmd_d   = CMD_PRE;
          obank_d = bank_q;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      is_wr_q <= 1'b0;
      bank_q  <= '0;
      col_q   <= '0;
      left_q  <= '0;
      cmd_q   <= CMD_NOP;
      obank_q <= '0;
      oaddr_q <= '0;
    end else begin
      state_q <= state_d;
      col_q   <= col_d;
      left_q  <= left_d;
      cmd_q   <= cmd_d;
      obank_q <= obank_d;
      oaddr_q <= oaddr_d;
      if (accept) begin
        is_wr_q <= txn_write;
        bank_q  <= txn_bank;
      end
    end
  end

  assign rq_cmd  = cmd_q;
  assign rq_bank = obank_q;
  assign rq_addr = oaddr_q;

  seq_pulse_delay #(.DEPTH(T_WR_DATA)) u_wr_dly (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (cmd_q == CMD_WR),
    .dout  (wr_strobe)
  );

  seq_pulse_delay #(.DEPTH(T_RD_DATA)) u_rd_dly (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (cmd_q == CMD_RD),
    .dout  (rd_capture)
  );

endmodule

// File: rtl/dram_req_seq_chk.sv
module dram_req_seq_chk
  import dram_seq_pkg::*;
#(
  parameter int BANK_W    = 3,
  parameter int ROW_W     = 12,
  parameter int COL_W     = 6,
  parameter int T_ACT_WR  = 1,
  parameter int T_ACT_RD  = 5,
  parameter int T_COL     = 2,
  parameter int T_WR_PRE  = 10,
  parameter int T_RD_PRE  = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  txn_valid,
  input logic                  txn_ready,
  input logic [BANK_W-1:0]     txn_bank,
  input logic [2:0]            rq_cmd,
  input logic [BANK_W-1:0]     rq_bank,
  input logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] rq_addr,
  input logic                  wr_strobe,
  input logic                  rd_capture
);

  logic [15:0] since_act_q;
  logic [15:0] since_col_q;
  logic        first_pend_q;
  logic        last_wr_q;
  logic [7:0]  wr_owed_q;
  logic [7:0]  rd_owed_q;
  logic        is_col;

  assign is_col = (rq_cmd == CMD_WR) || (rq_cmd == CMD_RD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_act_q  <= '0;
      since_col_q  <= '0;
      first_pend_q <= 1'b0;
      last_wr_q    <= 1'b0;
      wr_owed_q    <= '0;
      rd_owed_q    <= '0;
    end else begin
      if (rq_cmd == CMD_ACT) begin
        since_act_q <= 16'd1;
      end else if (since_act_q != 16'hFFFF) begin
        since_act_q <= since_act_q + 16'd1;
      end
      if (is_col) begin
        since_col_q <= 16'd1;
      end else if (since_col_q != 16'hFFFF) begin
        since_col_q <= since_col_q + 16'd1;
      end
      if (rq_cmd == CMD_ACT) begin
        first_pend_q <= 1'b1;
      end else if (is_col) begin
        first_pend_q <= 1'b0;
      end
      if (is_col) begin
        last_wr_q <= (rq_cmd == CMD_WR);
      end
      wr_owed_q <= wr_owed_q + {7'd0, rq_cmd == CMD_WR} - {7'd0, wr_strobe};
      rd_owed_q <= rd_owed_q + {7'd0, rq_cmd == CMD_RD} - {7'd0, rd_capture};
    end
  end

  AST_NOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_cmd == CMD_NOP) |-> (rq_bank == '0 && rq_addr == '0)); // R9
  AST_LEGAL_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    rq_cmd <= 3'd4); // R9
  AST_ACT_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && txn_ready) |=> (rq_cmd == CMD_ACT && rq_bank == $past(txn_bank))); // R2
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_cmd == CMD_ACT || is_col) |-> !txn_ready); // R2
  AST_PRE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_cmd == CMD_PRE) |-> txn_ready); // R2
  AST_FIRST_WR_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_cmd == CMD_WR && first_pend_q) |-> since_act_q >= 16'(T_ACT_WR)); // R4
  AST_FIRST_RD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_cmd == CMD_RD && first_pend_q) |-> since_act_q >= 16'(T_ACT_RD)); // R4
  AST_COL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (is_col && !first_pend_q) |-> since_col_q >= 16'(T_COL)); // R5
  AST_PRE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_cmd == CMD_PRE) |-> since_col_q >= (last_wr_q ? 16'(T_WR_PRE) : 16'(T_RD_PRE))); // R6
  AST_WR_STROBE_OWED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> wr_owed_q != '0); // R7
  AST_RD_CAPTURE_OWED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_capture |-> rd_owed_q != '0); // R8

endmodule

bind dram_req_seq dram_req_seq_chk #(
  .BANK_W   (BANK_W),
  .ROW_W    (ROW_W),
  .COL_W    (COL_W),
  .T_ACT_WR (T_ACT_WR),
  .T_ACT_RD (T_ACT_RD),
  .T_COL    (T_COL),
  .T_WR_PRE (T_WR_PRE),
  .T_RD_PRE (T_RD_PRE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .txn_valid  (txn_valid),
  .txn_ready  (txn_ready),
  .txn_bank   (txn_bank),
  .rq_cmd     (rq_cmd),
  .rq_bank    (rq_bank),
  .rq_addr    (rq_addr),
  .wr_strobe  (wr_strobe),
  .rd_capture (rd_capture)
);

// File: tb/dram_req_seq_bench.sv
`timescale 1ns/1ps
module dram_req_seq_bench;

  localparam int BANK_W = 3, ROW_W = 12, COL_W = 6, NCOL_W = 4;
  localparam int T_ACT_WR = 1, T_ACT_RD = 5, T_COL = 2;
  localparam int T_WR_DATA = 3, T_RD_DATA = 6, T_WR_PRE = 10, T_RD_PRE = 3;
  localparam int ADDR_W = 12;
  localparam int COL_MOD = 1 << COL_W;

  logic clk = 1'b0;
  logic rst_n;
  logic txn_valid, txn_ready, txn_write;
  logic [BANK_W-1:0] txn_bank;
  logic [ROW_W-1:0]  txn_row;
  logic [COL_W-1:0]  txn_col;
  logic [NCOL_W-1:0] txn_cols_m1;
  logic [2:0]        rq_cmd;
  logic [BANK_W-1:0] rq_bank;
  logic [ADDR_W-1:0] rq_addr;
  logic wr_strobe, rd_capture;

  always #2 clk = ~clk;

  dram_req_seq u_dram_req_seq (
    .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .txn_ready(txn_ready),
    .txn_write(txn_write), .txn_bank(txn_bank), .txn_row(txn_row),
    .txn_col(txn_col), .txn_cols_m1(txn_cols_m1), .rq_cmd(rq_cmd),
    .rq_bank(rq_bank), .rq_addr(rq_addr), .wr_strobe(wr_strobe),
    .rd_capture(rd_capture)
  );

  int tests = 0;
  int fails = 0;
  int edges = 0;
  bit reported = 0;

  // Behavioural reference: expected events keyed by cycle number
  int    e_cmd[int];
  int    e_bank[int];
  int    e_addr[int];
  string e_tag[int];
  bit    e_w[int];
  bit    e_r[int];
  int    busy_lo = -1;
  int    busy_hi = -1;
  int    last_pre = -100;
  string nop_tag = "R9";

  always @(posedge clk) edges <= edges + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", tag, what, act, exp, edges);
    end
  endtask

  task automatic schedule(input int a, input bit w, input int bank, input int row,
                          input int col, input int m1);
    int c;
    int p;
    e_cmd[a] = 1; e_bank[a] = bank; e_addr[a] = row;
    e_tag[a] = (a == last_pre + 1) ? "R10" : "R2";
    c = a + (w ? T_ACT_WR : T_ACT_RD);
    for (int k = 0; k <= m1; k++) begin
      e_cmd[c] = w ? 2 : 3;
      e_bank[c] = bank;
      e_addr[c] = (col + k) % COL_MOD;
      e_tag[c] = ((col + k) >= COL_MOD) ? "R3" : ((k == 0) ? "R4" : "R5");
      if (w) e_w[c + T_WR_DATA] = 1'b1;
      else   e_r[c + T_RD_DATA] = 1'b1;
      if (k < m1) c = c + T_COL;
    end
    p = c + (w ? T_WR_PRE : T_RD_PRE);
    e_cmd[p] = 4; e_bank[p] = bank; e_addr[p] = 0; e_tag[p] = "R6";
    busy_lo = a; busy_hi = p; last_pre = p;
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      chk(rq_cmd == 3'd0 && rq_bank == '0 && rq_addr == '0, "R1", "reset packet",
          int'({rq_cmd, rq_bank, rq_addr}), 0);
      chk(!wr_strobe && !rd_capture && txn_ready, "R1", "reset strobes/ready",
          int'({wr_strobe, rd_capture, txn_ready}), 1);
    end else begin
      int e;
      int xc, xb, xa;
      string tg;
      bit xw, xr, xrdy;
      e  = edges;
      xc = e_cmd.exists(e) ? e_cmd[e] : 0;
      xb = e_cmd.exists(e) ? e_bank[e] : 0;
      xa = e_cmd.exists(e) ? e_addr[e] : 0;
      tg = e_cmd.exists(e) ? e_tag[e] : nop_tag;
      chk(int'(rq_cmd) == xc && int'(rq_bank) == xb && int'(rq_addr) == xa, tg,
          "cmd/bank/addr", int'({rq_cmd, rq_bank, rq_addr}),
          (xc << (BANK_W + ADDR_W)) | (xb << ADDR_W) | xa);
      xw = e_w.exists(e) ? 1'b1 : 1'b0;
      xr = e_r.exists(e) ? 1'b1 : 1'b0;
      chk(wr_strobe == xw, "R7", "wr_strobe", int'(wr_strobe), int'(xw));
      chk(rd_capture == xr, "R8", "rd_capture", int'(rd_capture), int'(xr));
      xrdy = !(e >= busy_lo && e < busy_hi);
      chk(txn_ready == xrdy, "R2", "txn_ready", int'(txn_ready), int'(xrdy));
      if (txn_valid && txn_ready)
        schedule(e + 1, txn_write, int'(txn_bank), int'(txn_row), int'(txn_col),
                 int'(txn_cols_m1));
    end
  end

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
    end
  endtask

  // Called just after a rising edge; returns just after the accepting edge
  task automatic send(input bit w, input int bank, input int row, input int col,
                      input int m1);
    bit ok;
    txn_write   = w;
    txn_bank    = BANK_W'(bank);
    txn_row     = ROW_W'(row);
    txn_col     = COL_W'(col);
    txn_cols_m1 = NCOL_W'(m1);
    txn_valid   = 1'b1;
    do begin
      @(negedge clk);
      ok = txn_ready;
      @(posedge clk);
    end while (!ok);
    #1 txn_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!txn_ready);
    @(posedge clk);
    #1;
  endtask

  initial begin
    rst_n = 1'b0;
    txn_valid = 1'b0; txn_write = 1'b0; txn_bank = '0;
    txn_row = '0; txn_col = '0; txn_cols_m1 = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    // Two-column write, two-column read (R3 R4 R5 R6 R7 R8)
    send(1'b1, 3, 12'h5A5, 10, 1);
    wait_idle();
    send(1'b0, 5, 12'h123, 20, 1);
    wait_idle();
    // Single-column write, then a request withdrawn while busy (R11)
    send(1'b1, 0, 0, 0, 0);
    nop_tag = "R11";
    txn_write = 1'b0; txn_bank = 3'd6; txn_row = 12'hABC;
    txn_col = 6'd33; txn_cols_m1 = 4'd7; txn_valid = 1'b1;
    repeat (4) @(posedge clk);
    #1 txn_valid = 1'b0;
    wait_idle();
    nop_tag = "R9";
    // Column wrap read, then back-to-back write and read (R3 R10)
    send(1'b0, 7, 12'hFFF, 62, 3);
    send(1'b1, 2, 12'h0F0, 63, 2);
    send(1'b0, 1, 12'h00F, 5, 0);
    wait_idle();
    repeat (12) @(posedge clk);
    report();
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

endmodule